// File: doc/BRIEF.md
# PLL Serial Reconfiguration Sequencer

This block loads a fresh settings word into a PLL through the PLL's three-wire serial configuration port and orders the resets around that load. A request carries the divider values (reference, feedback and output), the loop-filter range, the feedback-mux and output-mux choices and a few single-bit options. On acceptance the block packs these into one word, puts the downstream logic into reset, holds the PLL in reset, clocks the word out most significant bit first and releases the PLL. It then waits for lock and only after that lets the downstream logic run.

The whole block runs from a free-running system clock that does not come from the PLL, because no PLL output runs while the PLL is held in reset. The serial clock is the system clock divided down. A parameter picks a 26-bit word or a 27-bit word that carries one extra shift-register bit.

The request uses a valid/ready handshake. `start_ready` is high only while the block is idle. A request is taken on the first rising clock edge at which `start_valid` and `start_ready` are both high, and every settings input is sampled on that edge. While the block is busy, `start_ready` is low and requests are not taken. A requester may hold `start_valid` high across that time, and the request is then taken once the block is idle again.

Top module: `pll_cfg_loader`

## Requirements
- R1: After reset `logic_rst`=1, `pll_rst_n`=1, `sclk`=1, `busy`=0, `done`=0, `err`=0 and `start_ready`=1.
- R2: A request is accepted only on an edge where `start_valid` and `start_ready` are both high. `start_ready` equals the inverse of `busy`. A request presented while busy has no effect on the word that is loaded.
- R3: Word bit positions: DIVR in [3:0], DIVF in [10:4], DIVQ in [13:11], filter range in [16:14], feedback mux in [18:17] (0 = delay, 1 = phase and delay, 3 = external), output-2 select in [20:19], shift-register bit 0 in [21], reference source in [22] (0 = pad, 1 = fabric), output-1 select in [24:23] (0 = 0°, 1 = 90°, 2 = generated, 3 = generated divided by two), simple-feedback flag in [25].
- R4: With `WORD_W`=27, shift-register bit 1 occupies [26]. With `WORD_W`=26 the word is [25:0] and `sr1` is not sent.
- R5: The word is sent most significant bit first, with exactly `WORD_W` falling `sclk` edges per load. `sdat` changes only together with a rising `sclk` edge and never on a falling edge.
- R6: `sclk` is high whenever `pll_rst_n` is high. Each low phase of `sclk` lasts `HALF_DIV` system cycles.
- R7: `logic_rst` is high during every cycle in which `pll_rst_n` is low.
- R8: `pll_rst_n` stays low for at least `RST_GUARD` cycles before the first falling `sclk` edge, and for at least `RST_GUARD` cycles after the last rising edge.
- R9: After `pll_rst_n` rises, the first cycle with `lock` high ends the load. On the next edge `logic_rst` falls, `done` goes to 1 and `busy` goes to 0.
- R10: If `lock` is not seen within `LOCK_TIMEOUT` cycles, `err` goes to 1, `logic_rst` stays 1 and `busy` goes to 0.
- R11: `done` and `err` are never both high. Both are cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock, independent of the PLL |
| rst_n | input | 1 | active-low asynchronous reset |
| start_valid | input | 1 | load request valid |
| start_ready | output | 1 | block idle and able to take a request |
| divr | input | 4 | reference divider |
| divf | input | 7 | feedback divider |
| divq | input | 3 | output divider |
| filt | input | 3 | loop-filter range |
| fb_mux | input | 2 | feedback-path mux select |
| out1_sel | input | 2 | output 1 mux select |
| out2_sel | input | 2 | output 2 mux select |
| ref_src | input | 1 | reference source, 0 = pad, 1 = fabric |
| sr0 | input | 1 | shift-register option bit 0 |
| sr1 | input | 1 | shift-register option bit 1 (27-bit word only) |
| simple_fb | input | 1 | simple feedback mode flag |
| lock | input | 1 | PLL lock indication |
| logic_rst | output | 1 | reset for logic clocked by PLL outputs, active high |
| pll_rst_n | output | 1 | PLL reset, active low |
| sclk | output | 1 | serial configuration clock, idles high |
| sdat | output | 1 | serial configuration data |
| busy | output | 1 | load in progress |
| done | output | 1 | last load completed with lock |
| err | output | 1 | last load timed out waiting for lock |

## Verification
A wrong bit counter or a wrong shift-register step shows on the next PLL reset release as a captured word that differs from the requested one, or as a falling-edge count other than `WORD_W`. A wrong state order shows in the same cycle, as `pll_rst_n` low while `logic_rst` is low, or as `sclk` toggling outside the window. A guard or divider count that is off shows within one load as a short low phase. A lock-wait fault shows as `done` or `err` in the wrong state once `busy` drops.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_PRE, ST_SHIFT, ST_POST, ST_LOCK
  } st_e;

  // field order equals bit order of the full 27-bit word, MSB first
  typedef struct packed {
    logic       sr1;
    logic       simple_fb;
    logic [1:0] out1_sel;
    logic       ref_src;
    logic       sr0;
    logic [1:0] out2_sel;
    logic [1:0] fb_mux;
    logic [2:0] filt;
    logic [2:0] divq;
    logic [6:0] divf;
    logic [3:0] divr;
  } cfg_t;

  function automatic logic [26:0] pack_cfg(input cfg_t c);
    return c;
  endfunction

endpackage

// File: rtl/pcl_tick.sv
module pcl_tick #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!en || tick)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pcl_shreg.sv
module pcl_shreg #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] q;

  assign msb = q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader #(
  parameter int WORD_W       = 27,   // 26 or 27
  parameter int HALF_DIV     = 4,    // system cycles per sclk phase
  parameter int RST_GUARD    = 8,    // PLL reset margin around the shift window
  parameter int LOCK_TIMEOUT = 1000  // cycles allowed for lock
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  output logic       start_ready,
  input  logic [3:0] divr,
  input  logic [6:0] divf,
  input  logic [2:0] divq,
  input  logic [2:0] filt,
  input  logic [1:0] fb_mux,
  input  logic [1:0] out1_sel,
  input  logic [1:0] out2_sel,
  input  logic       ref_src,
  input  logic       sr0,
  input  logic       sr1,
  input  logic       simple_fb,
  input  logic       lock,
  output logic       logic_rst,
  output logic       pll_rst_n,
  output logic       sclk,
  output logic       sdat,
  output logic       busy,
  output logic       done,
  output logic       err
);
  import pcl_pkg::*;

  localparam int BIT_W = $clog2(WORD_W);
  localparam int GW    = $clog2(RST_GUARD + 1);
  localparam int TW    = $clog2(LOCK_TIMEOUT + 1);

  st_e               state;
  cfg_t              cfg_in;
  logic [26:0]       full_word;
  logic [WORD_W-1:0] load_word;
  logic [BIT_W-1:0]  bcnt;
  logic [GW-1:0]     gcnt;
  logic [TW-1:0]     tcnt;
  logic              accept, tick, shift_en;

  assign cfg_in = '{sr1: sr1, simple_fb: simple_fb, out1_sel: out1_sel,
                    ref_src: ref_src, sr0: sr0, out2_sel: out2_sel,
                    fb_mux: fb_mux, filt: filt, divq: divq, divf: divf,
                    divr: divr};
  assign full_word = pack_cfg(cfg_in);

  generate
    if (WORD_W == 27) begin : g_long
      assign load_word = full_word;
    end else begin : g_short
      assign load_word = full_word[WORD_W-1:0];
    end
  endgenerate

  assign start_ready = (state == ST_IDLE);
  assign busy        = (state != ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign shift_en    = tick && !sclk;   // rising sclk edge advances data

  pcl_tick #(.HALF(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(state == ST_SHIFT), .tick(tick)
  );

  pcl_shreg #(.W(WORD_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(load_word),
    .shift(shift_en), .msb(sdat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      logic_rst <= 1'b1;
      pll_rst_n <= 1'b1;
      sclk      <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      bcnt      <= '0;
      gcnt      <= '0;
      tcnt      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          done      <= 1'b0;
          err       <= 1'b0;
          logic_rst <= 1'b1;
          state     <= ST_HOLD;
        end
        ST_HOLD: begin
          pll_rst_n <= 1'b0;
          gcnt      <= '0;
          state     <= ST_PRE;
        end
        ST_PRE: begin
          if (gcnt == GW'(RST_GUARD - 1)) begin
            gcnt  <= '0;
            bcnt  <= '0;
            state <= ST_SHIFT;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_SHIFT: if (tick) begin
          if (sclk) begin
            sclk <= 1'b0;
          end else begin
            sclk <= 1'b1;
            if (bcnt == BIT_W'(WORD_W - 1)) begin
              gcnt  <= '0;
              state <= ST_POST;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_POST: begin
          if (gcnt == GW'(RST_GUARD - 1)) begin
            pll_rst_n <= 1'b1;
            tcnt      <= '0;
            state     <= ST_LOCK;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_LOCK: begin
          if (lock) begin
            logic_rst <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end else if (tcnt == TW'(LOCK_TIMEOUT - 1)) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcl_checks.sv
module pcl_checks (
  input logic clk,
  input logic rst_n,
  input logic logic_rst,
  input logic pll_rst_n,
  input logic sclk,
  input logic sdat,
  input logic lock,
  input logic busy,
  input logic done,
  input logic err
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst_n |-> sclk);                                        // R6
  AST_LOGIC_COVERS_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_rst_n |-> logic_rst);                                  // R7
  AST_DATA_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdat));                             // R5
  AST_RELEASE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_rst) |-> $past(lock) && done && !busy);         // R9
  AST_ERR_KEEPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> logic_rst && pll_rst_n);                            // R10
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);                                             // R11
endmodule

bind pll_cfg_loader pcl_checks u_chk (
  .clk(clk), .rst_n(rst_n), .logic_rst(logic_rst), .pll_rst_n(pll_rst_n),
  .sclk(sclk), .sdat(sdat), .lock(lock), .busy(busy), .done(done), .err(err)
);

// File: tb/sim_pll_cfg_loader.sv
module pll_stub #(
  parameter int W        = 27,
  parameter int LOCK_DLY = 10
) (
  input  logic         clk,
  input  logic         rst_pll_n,
  input  logic         sclk,
  input  logic         sdat,
  input  logic         lock_en,
  output logic         lock,
  output logic [W-1:0] got,
  output int           got_n,
  output int           stray,
  output int           pre_low,
  output int           post_low
);
  logic [W-1:0] sh = '0;
  logic sclk_d = 1'b1, rst_d = 1'b1;
  int nf = 0, low_cnt = 0, since_rise = 0, lcnt = 0;

  initial begin
    lock = 0; got = '0; got_n = 0; stray = 0; pre_low = 0; post_low = 0;
  end

  always @(posedge clk) begin
    sclk_d <= sclk;
    rst_d  <= rst_pll_n;
    low_cnt    <= (rst_d && !rst_pll_n) ? 0 : low_cnt + 1;
    since_rise <= (!sclk_d && sclk) ? 0 : since_rise + 1;
    if (sclk_d && !sclk) begin
      if (!rst_pll_n) begin
        sh <= {sh[W-2:0], sdat};
        nf <= nf + 1;
        if (nf == 0) pre_low <= low_cnt;
      end else stray <= stray + 1;
    end else if (rst_d && !rst_pll_n) nf <= 0;
    if (!rst_d && rst_pll_n) begin
      got <= sh; got_n <= nf; post_low <= since_rise;
    end
    if (!rst_pll_n) begin lcnt <= 0; lock <= 0; end
    else if (lock_en) begin
      if (lcnt < LOCK_DLY) lcnt <= lcnt + 1;
      lock <= (lcnt == LOCK_DLY);
    end
  end
endmodule

module sim_pll_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3, GUARD = 4, TMO = 60, LDLY = 10;

  logic clk = 0, rst_n = 0, start_valid = 0, lock_en = 1;
  logic [3:0] divr = 0; logic [6:0] divf = 0; logic [2:0] divq = 0, filt = 0;
  logic [1:0] fb_mux = 0, out1_sel = 0, out2_sel = 0;
  logic ref_src = 0, sr0 = 0, sr1 = 0, simple_fb = 0;

  logic rdy0, lr0, pr0, sc0, sd0, bz0, dn0, er0, lk0;
  logic rdy1, lr1, pr1, sc1, sd1, bz1, dn1, er1, lk1;
  logic [26:0] got0; logic [25:0] got1;
  int n0, n1, st0, st1, pre0, pre1, post0, post1;
  int total = 0, bad = 0, cyc = 0;
  int ord_v = 0, idle_v = 0, fall_v = 0, half_v = 0, low_len = 0;
  logic sc0_p = 1, sd0_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_cfg_loader #(.WORD_W(27), .HALF_DIV(HALF), .RST_GUARD(GUARD), .LOCK_TIMEOUT(TMO)) u0 (
    .clk, .rst_n, .start_valid, .start_ready(rdy0), .divr, .divf, .divq, .filt,
    .fb_mux, .out1_sel, .out2_sel, .ref_src, .sr0, .sr1, .simple_fb, .lock(lk0),
    .logic_rst(lr0), .pll_rst_n(pr0), .sclk(sc0), .sdat(sd0), .busy(bz0), .done(dn0), .err(er0));
  pll_cfg_loader #(.WORD_W(26), .HALF_DIV(HALF), .RST_GUARD(GUARD), .LOCK_TIMEOUT(TMO)) u1 (
    .clk, .rst_n, .start_valid, .start_ready(rdy1), .divr, .divf, .divq, .filt,
    .fb_mux, .out1_sel, .out2_sel, .ref_src, .sr0, .sr1, .simple_fb, .lock(lk1),
    .logic_rst(lr1), .pll_rst_n(pr1), .sclk(sc1), .sdat(sd1), .busy(bz1), .done(dn1), .err(er1));

  pll_stub #(.W(27), .LOCK_DLY(LDLY)) s0 (.clk, .rst_pll_n(pr0), .sclk(sc0), .sdat(sd0),
    .lock_en, .lock(lk0), .got(got0), .got_n(n0), .stray(st0), .pre_low(pre0), .post_low(post0));
  pll_stub #(.W(26), .LOCK_DLY(LDLY)) s1 (.clk, .rst_pll_n(pr1), .sclk(sc1), .sdat(sd1),
    .lock_en, .lock(lk1), .got(got1), .got_n(n1), .stray(st1), .pre_low(pre1), .post_low(post1));

  // continuous port monitors, sampled away from the active edge
  always @(negedge clk) if (rst_n) begin
    if ((!pr0 && !lr0) || (!pr1 && !lr1)) ord_v++;            // R7
    if ((pr0 && !sc0) || (pr1 && !sc1)) idle_v++;             // R6
    if (sc0_p && !sc0 && sd0 != sd0_p) fall_v++;              // R5
    if (!sc0) low_len++;
    else begin
      if (!sc0_p && low_len != HALF) half_v++;                // R6
      low_len = 0;
    end
    sc0_p = sc0; sd0_p = sd0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_word();
    logic [26:0] w = '0;
    w[26] = sr1;      w[25] = simple_fb; w[24:23] = out1_sel; w[22] = ref_src;
    w[21] = sr0;      w[20:19] = out2_sel; w[18:17] = fb_mux; w[16:14] = filt;
    w[13:11] = divq;  w[10:4] = divf;    w[3:0] = divr;
    return w;
  endfunction

  task automatic set_fields(input logic [26:0] v);
    {sr1, simple_fb, out1_sel, ref_src, sr0, out2_sel, fb_mux, filt, divq, divf, divr} = v;
  endtask

  task automatic do_load(input logic [26:0] v, input bit lock_on, input bit poke);
    logic [26:0] e;
    int t = 0;
    set_fields(v);
    e = exp_word();
    lock_en = lock_on;
    start_valid = 1;
    @(negedge clk);
    start_valid = 0;
    chk(bz0 && bz1 && !rdy0 && !rdy1, "R2 accept", {bz0, bz1, rdy0, rdy1}, 4'b1100);
    chk(!dn0 && !er0 && !dn1 && !er1, "R11 clear", {dn0, er0, dn1, er1}, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      set_fields(~v);
      start_valid = 1;
      repeat (5) @(negedge clk);
      chk(!rdy0, "R2 busy ready", rdy0, 0);
      start_valid = 0;
    end
    while ((bz0 || bz1) && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R9 finish", t, 0);
    repeat (2) @(negedge clk);
    chk(!bz0 && !bz1 && rdy0, "R2 idle", {bz0, bz1}, 0);
    chk(got0 == e, "R3 word 27", got0, e);
    chk(got1 == e[25:0], "R4 word 26", got1, e[25:0]);
    chk(n0 == 27 && n1 == 26, "R5 fall count", {n0[15:0], n1[15:0]}, {16'd27, 16'd26});
    chk(pre0 >= GUARD && post0 + 1 >= GUARD, "R8 guard", {pre0[15:0], post0[15:0]}, GUARD);
    if (lock_on) begin
      chk(dn0 && !er0 && !lr0 && dn1 && !lr1, "R9 locked", {dn0, er0, lr0, dn1, lr1}, 5'b10010);
    end else begin
      chk(er0 && !dn0 && lr0 && er1 && lr1, "R10 timeout", {er0, dn0, lr0, er1, lr1}, 5'b10111);
    end
  endtask

  initial begin
    void'($urandom(32'd7013));
    #(CLK_PERIOD * 3 + 1);
    chk(lr0 && pr0 && sc0 && !bz0 && !dn0 && !er0 && rdy0, "R1 reset",
        {lr0, pr0, sc0, bz0, dn0, er0, rdy0}, 7'b1110001);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(lr1 && pr1 && sc1 && !bz1 && rdy1, "R1 reset u1", {lr1, pr1, sc1, bz1, rdy1}, 5'b11101);
    do_load(27'h0000000, 1, 0);
    do_load(27'h7FFFFFF, 1, 0);
    do_load(27'h4000001, 1, 1);                 // R2 request while busy ignored
    do_load(27'h2A5A5A5, 0, 0);                 // R10 lock never arrives
    chk(st0 == 0 && st1 == 0, "R6 stray edges", st0 + st1, 0);
    for (int i = 0; i < 8; i++) do_load(27'($urandom), 1, (i % 3) == 0);
    chk(ord_v == 0, "R7 order", ord_v, 0);
    chk(idle_v == 0, "R6 idle high", idle_v, 0);
    chk(half_v == 0, "R6 half period", half_v, 0);
    chk(fall_v == 0, "R5 data on fall", fall_v, 0);
    chk(st0 == 0 && st1 == 0, "R6 stray edges end", st0 + st1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule